// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash memory. It decides whether a program or erase operation the host has already started has finished, and whether it finished well. After a start pulse it reads the device status word over a simple strobe-and-ready bus and watches two bits. Bit 6 flips on every status read while the operation runs. Bit 5 rises when the device gives up on the operation. The block never issues the program or erase commands itself.

Status reads are taken in pairs. When bit 6 is the same in both reads of a pair, the operation is over and the result is pass. When it differs and bit 5 is still low, another pair follows. When it differs and bit 5 is high, one more confirming pair is taken, because the toggling can stop in the same moment that bit 5 rises. If that confirming pair still shows a change, the result is fail and the block writes the F0h return-to-read command to the device. An optional cap on the number of pairs forces a fail that is flagged as a timeout. An abort input ends monitoring with no result. The next start always begins with a fresh pair.

Top module: `tbit_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_rd`, `bus_wr`, `busy`, `done`, `pass`, `fail` and `poll_timeout` are all low.
- R2: Each bus transfer holds its strobe and `bus_addr` steady until a cycle with `bus_ready` high; read data is taken in that cycle; every transfer addresses the `status_addr` captured at start; `bus_rd` and `bus_wr` are never high together.
- R3: Between the end of one bus transfer and the rise of the next strobe, both strobes stay low for at least `GAP` cycles.
- R4: Status reads come in pairs; if bit 6 is equal in both reads of a pair, the block reports pass after exactly that pair, with no write.
- R5: If bit 6 differs within a pair and bit 5 of the pair's second read is 0, a further pair of reads is taken.
- R6: If bit 6 differs and bit 5 of the second read is 1, one confirming pair follows; if bit 6 is equal in the confirming pair, the result is pass.
- R7: If bit 6 still differs in the confirming pair, the result is fail, and a single write of F0h (`bus_wdata`) to the status address completes before `done`.
- R8: When `MAX_PAIRS` pairs have completed without a pass or fail decision, the block writes F0h and reports fail with `poll_timeout` high; `poll_timeout` is never high without `fail`.
- R9: `done` is high for exactly one cycle per finished poll, with `busy` low; `pass` and `fail` are never both high, hold their values after `done`, and clear in the cycle after a start is accepted.
- R10: An abort while reading lets the transfer in flight finish, then returns to idle with no `done`; the next start begins with a new pair of two reads and reuses nothing stored before.
- R11: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a poll |
| abort | input | 1 | Abandon the poll in progress |
| status_addr | input | AW | Address used for status reads and the reset write |
| busy | output | 1 | A poll or abort drain is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed or poll cap reached |
| poll_timeout | output | 1 | Fail was caused by the pair cap |
| bus_addr | output | AW | Memory bus address |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with ready |
| bus_ready | input | 1 | Transfer completes in this cycle |

## Verification
The bench builds the block with `GAP` = 2 and `MAX_PAIRS` = 4. With a cap this small, every way a poll can end comes up within a few pairs: an immediate pass, a pass after several toggling pairs, a pass or fail on the confirming pair, and the forced timeout. The bench sweeps the read at which toggling stops against the read at which bit 5 rises and against two ready latencies. For each case it derives the expected result, read count and write count from the pairing rules.

// File: rtl/tbp_pkg.sv
// Shared types for the toggle-bit poller.
// Assumes: nothing beyond IEEE 1800-2017.
package tbp_pkg;

    // Bus engine states.
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_ACT  = 2'd1,
        ENG_GAP  = 2'd2
    } eng_state_t;

    // Poll controller states.
    typedef enum logic [2:0] {
        PC_IDLE  = 3'd0,
        PC_RD    = 3'd1,
        PC_RWAIT = 3'd2,
        PC_WR    = 3'd3,
        PC_WWAIT = 3'd4,
        PC_DRAIN = 3'd5
    } poll_state_t;

endpackage

// File: rtl/tbp_bus_engine.sv
// Runs single read or write transfers on a strobe/ready bus.
// It accepts a go pulse only while idle, holds the strobe and address until
// ready, and then keeps the bus quiet for GAP cycles before it goes idle again.
// Assumes: the memory side raises ready for one cycle per transfer.
module tbp_bus_engine
    import tbp_pkg::*;
#(
    parameter int AW  = 17,
    parameter int DW  = 8,
    parameter int GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_rd,
    input  logic          go_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          idle,
    output logic          ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready
);
    localparam int GW = (GAP > 0) ? $clog2(GAP + 1) : 1;

    eng_state_t    st;
    logic [GW-1:0] gcnt;

    assign idle = (st == ENG_IDLE);
    assign ack  = (st == ENG_ACT) && bus_ready;

    // Transfer sequencing and the enforced idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ENG_IDLE;
            gcnt      <= '0;
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (go_rd || go_wr) begin
                        bus_rd    <= go_rd;
                        bus_wr    <= go_wr && !go_rd;
                        bus_addr  <= addr;
                        bus_wdata <= wdata;
                        st        <= ENG_ACT;
                    end
                end
                ENG_ACT: begin
                    if (bus_ready) begin
                        bus_rd <= 1'b0;
                        bus_wr <= 1'b0;
                        if (GAP > 0) begin
                            gcnt <= GW'(GAP);
                            st   <= ENG_GAP;
                        end else begin
                            st   <= ENG_IDLE;
                        end
                    end
                end
                ENG_GAP: begin
                    if (gcnt <= GW'(1)) st <= ENG_IDLE;
                    gcnt <= gcnt - GW'(1);
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tbp_ctrl.sv
// Poll decision controller: pairs status reads, compares the toggle bit,
// handles the timeout-flag confirming pair, the pair cap and abort, and
// orders the reset write on failure.
// Assumes: tbit/fbit are the read data bits, valid in the eng_ack cycle.
module tbp_ctrl
    import tbp_pkg::*;
#(
    parameter int AW        = 17,
    parameter int MAX_PAIRS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] status_addr,
    input  logic          eng_idle,
    input  logic          eng_ack,
    input  logic          tbit,
    input  logic          fbit,
    output logic          go_rd,
    output logic          go_wr,
    output logic [AW-1:0] op_addr,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          poll_timeout
);
    localparam int  PW    = $clog2(MAX_PAIRS + 2);
    localparam bit  LIMIT = (MAX_PAIRS > 0);

    poll_state_t   st;
    logic          second;
    logic          recheck;
    logic          t_prev;
    logic          abort_q;
    logic          timed;
    logic [PW-1:0] pairs;

    logic          toggled;
    logic          stop_req;
    logic [PW-1:0] pairs_nx;
    logic          cap_hit;

    // Decision terms for the read completing this cycle.
    always_comb begin
        toggled  = t_prev ^ tbit;
        stop_req = abort || abort_q;
        pairs_nx = pairs + PW'(1);
        cap_hit  = LIMIT && (pairs_nx == PW'(MAX_PAIRS));
    end

    assign go_rd = (st == PC_RD) && eng_idle && !stop_req;
    assign go_wr = (st == PC_WR) && eng_idle;
    assign busy  = (st != PC_IDLE);

    // Poll sequencing, result flags and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= PC_IDLE;
            second       <= 1'b0;
            recheck      <= 1'b0;
            t_prev       <= 1'b0;
            abort_q      <= 1'b0;
            timed        <= 1'b0;
            pairs        <= '0;
            op_addr      <= '0;
            done         <= 1'b0;
            pass         <= 1'b0;
            fail         <= 1'b0;
            poll_timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            if ((st == PC_RD || st == PC_RWAIT) && abort) abort_q <= 1'b1;
            case (st)
                PC_IDLE: begin
                    if (start) begin
                        op_addr      <= status_addr;
                        second       <= 1'b0;
                        recheck      <= 1'b0;
                        timed        <= 1'b0;
                        abort_q      <= 1'b0;
                        pairs        <= '0;
                        pass         <= 1'b0;
                        fail         <= 1'b0;
                        poll_timeout <= 1'b0;
                        st           <= PC_RD;
                    end
                end
                PC_RD: begin
                    if (stop_req)      st <= PC_DRAIN;
                    else if (eng_idle) st <= PC_RWAIT;
                end
                PC_RWAIT: begin
                    if (eng_ack) begin
                        if (stop_req) begin
                            st <= PC_DRAIN;
                        end else if (!second) begin
                            t_prev <= tbit;
                            second <= 1'b1;
                            st     <= PC_RD;
                        end else begin
                            second <= 1'b0;
                            pairs  <= pairs_nx;
                            if (!toggled) begin
                                pass <= 1'b1;
                                done <= 1'b1;
                                st   <= PC_IDLE;
                            end else if (recheck) begin
                                st <= PC_WR;
                            end else if (cap_hit) begin
                                timed <= 1'b1;
                                st    <= PC_WR;
                            end else begin
                                recheck <= fbit;
                                st      <= PC_RD;
                            end
                        end
                    end
                end
                PC_WR: begin
                    if (eng_idle) st <= PC_WWAIT;
                end
                PC_WWAIT: begin
                    if (eng_ack) begin
                        fail         <= 1'b1;
                        poll_timeout <= timed;
                        done         <= 1'b1;
                        st           <= PC_IDLE;
                    end
                end
                PC_DRAIN: begin
                    if (eng_idle) begin
                        abort_q <= 1'b0;
                        st      <= PC_IDLE;
                    end
                end
                default: st <= PC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tbit_poller.sv
// Top of the toggle-bit completion poller: joins the decision controller to
// the bus engine and fixes the reset command on the write data.
// Assumes: TBIT and FBIT lie inside the data width.
module tbit_poller #(
    parameter int          AW        = 17,
    parameter int          DW        = 8,
    parameter int          GAP       = 2,
    parameter int          MAX_PAIRS = 4,
    parameter int          TBIT      = 6,
    parameter int          FBIT      = 5,
    parameter logic [7:0]  RST_CMD   = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] status_addr,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          poll_timeout,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);
    logic          go_rd;
    logic          go_wr;
    logic          eng_idle;
    logic          eng_ack;
    logic [AW-1:0] op_addr;
    logic          unused_rdata;

    assign unused_rdata = ^bus_rdata;

    tbp_ctrl #(.AW(AW), .MAX_PAIRS(MAX_PAIRS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .status_addr(status_addr), .eng_idle(eng_idle), .eng_ack(eng_ack),
        .tbit(bus_rdata[TBIT]), .fbit(bus_rdata[FBIT]),
        .go_rd(go_rd), .go_wr(go_wr), .op_addr(op_addr), .busy(busy),
        .done(done), .pass(pass), .fail(fail), .poll_timeout(poll_timeout)
    );

    tbp_bus_engine #(.AW(AW), .DW(DW), .GAP(GAP)) u_eng (
        .clk(clk), .rst_n(rst_n), .go_rd(go_rd), .go_wr(go_wr),
        .addr(op_addr), .wdata(DW'(RST_CMD)), .idle(eng_idle), .ack(eng_ack),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready)
    );
endmodule

// File: rtl/tbit_poller_chk.sv
// Property checker for the toggle-bit poller, bound to every instance.
// Assumes: synchronous active-low reset; the bus gap is counted here.
module tbit_poller_chk #(
    parameter int         AW      = 17,
    parameter int         DW      = 8,
    parameter int         GAP     = 2,
    parameter logic [7:0] RST_CMD = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_ready,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          fail,
    input logic          poll_timeout
);
    logic [7:0] quiet;

    // Counts strobe-free cycles since the last completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          quiet <= 8'hFF;
        else if ((bus_rd || bus_wr) && bus_ready) quiet <= 8'h00;
        else if (!(bus_rd || bus_wr) && quiet != 8'hFF) quiet <= quiet + 8'h01;
    end

    p_rd_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> bus_rd);
    p_wr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> bus_wr);
    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !bus_ready) |=> $stable(bus_addr));
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_quiet_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd || bus_wr) |-> (int'(quiet) >= GAP));
    p_reset_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_wdata == DW'(RST_CMD)));
    p_timeout_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_timeout |-> fail);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (pass || fail)));
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
endmodule

bind tbit_poller tbit_poller_chk #(.AW(AW), .DW(DW), .GAP(GAP), .RST_CMD(RST_CMD)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .poll_timeout(poll_timeout)
);

// File: tb/sim_tbit_poller.sv
// Bench: sweeps toggle-stop read, timeout-flag read and ready latency.
module sim_tbit_poller;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int GAP = 2;
    localparam int MAXP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] status_addr = '0;
    logic          busy, done, pass, fail, poll_timeout;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;

    tbit_poller #(.AW(AW), .DW(DW), .GAP(GAP), .MAX_PAIRS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .status_addr(status_addr), .busy(busy), .done(done), .pass(pass),
        .fail(fail), .poll_timeout(poll_timeout), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_cnt, wr_cnt, wcnt, low_cnt, gap_bad, addr_bad, done_cnt;
    int s_stop, f_rise, lat;
    bit const_mode;
    logic [DW-1:0] wr_seen;
    logic [AW-1:0] exp_addr;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] status_word(int k);
        logic [DW-1:0] w;
        w = DW'(k & 31);
        if (const_mode) begin
            w[6] = 1'b1;
            w[5] = 1'b0;
        end else begin
            w[6] = (k < s_stop) ? k[0] : s_stop[0];
            w[5] = (k >= f_rise);
        end
        return w;
    endfunction

    // Memory-side responder; also measures the quiet gap and the address.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            wcnt <= 0;
            low_cnt <= 100;
        end else begin
            if (bus_rd || bus_wr) begin
                if (low_cnt < 100 && low_cnt < GAP) gap_bad++;
                low_cnt <= 100;
            end else if (low_cnt >= 100) begin
                low_cnt <= 100;
            end else begin
                low_cnt <= low_cnt + 1;
            end
            if (bus_ready) begin
                bus_ready <= 1'b0;
                wcnt <= 0;
                low_cnt <= 0;
            end else if (bus_rd || bus_wr) begin
                if (wcnt == lat) begin
                    bus_ready <= 1'b1;
                    if (bus_addr != exp_addr) addr_bad++;
                    if (bus_rd) begin
                        bus_rdata <= status_word(rd_cnt);
                        rd_cnt++;
                    end else begin
                        wr_seen = bus_wdata;
                        wr_cnt++;
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
            if (done) done_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Expected outcome from the pairing rules (R4..R8).
    task automatic predict(int s, int f, output bit p, output bit fl,
                           output bit to, output int reads);
        bit rc = 0;
        p = 0; fl = 0; to = 0; reads = 0;
        for (int pr = 0; pr < 64; pr++) begin
            bit tog = (2 * pr < s);
            bit b5  = (2 * pr + 1 >= f);
            reads = 2 * pr + 2;
            if (!tog) begin p = 1; return; end
            if (rc) begin fl = 1; return; end
            if (pr + 1 == MAXP) begin fl = 1; to = 1; return; end
            rc = b5;
        end
    endtask

    task automatic pulse_start(logic [AW-1:0] a);
        status_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(int s, int f, int l, bit poke);
        bit ep, ef, et;
        int er, w;
        string tag;
        s_stop = s; f_rise = f; lat = l; const_mode = 0;
        rd_cnt = 0; wr_cnt = 0; gap_bad = 0; addr_bad = 0; done_cnt = 0;
        wr_seen = '0;
        exp_addr = AW'((s * 4099 + f * 77 + l) & 17'h1FFFF);
        pulse_start(exp_addr);
        check(!pass && !fail && busy, "R9 clear on start", {pass, fail, busy}, 1);
        w = 0;
        while (!done && w < 600) begin
            if (poke && w == 3) begin
                status_addr = ~exp_addr;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
            w++;
        end
        predict(s, f, ep, ef, et, er);
        tag = $sformatf("s=%0d f=%0d lat=%0d", s, f, l);
        check(done, {"R9 done seen ", tag}, done, 1);
        check(pass == ep, {"R4 R6 pass ", tag}, pass, ep);
        check(fail == ef, {"R7 fail ", tag}, fail, ef);
        check(poll_timeout == et, {"R8 timeout ", tag}, poll_timeout, et);
        check(rd_cnt == er, {"R5 read count ", tag}, rd_cnt, er);
        check(wr_cnt == (ef ? 1 : 0), {"R7 write count ", tag}, wr_cnt, ef);
        if (ef) check(wr_seen == 8'hF0, {"R7 write data ", tag}, wr_seen, 8'hF0);
        check(addr_bad == 0, {"R2 R11 address ", tag}, addr_bad, 0);
        check(gap_bad == 0, {"R3 gap ", tag}, gap_bad, 0);
        repeat (3) @(negedge clk);
        check(done_cnt == 1, {"R9 one done ", tag}, done_cnt, 1);
        check(pass == ep && fail == ef && !busy, {"R9 held ", tag}, pass, ep);
    endtask

    initial begin
        lat = 0; s_stop = 0; f_rise = 99; const_mode = 0;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; gap_bad = 0; addr_bad = 0;
        exp_addr = '0;
        repeat (3) @(negedge clk);
        check(!bus_rd && !bus_wr && !busy && !done && !pass && !fail && !poll_timeout,
              "R1 during reset", {bus_rd, bus_wr, busy, done, pass, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_rd && !bus_wr && !busy && !done && !pass && !fail && !poll_timeout,
              "R1 after reset", {bus_rd, bus_wr, busy, done, pass, fail}, 0);

        for (int l = 0; l < 2; l++)
            for (int s = 0; s < 10; s++)
                for (int fi = 0; fi < 11; fi++)
                    run_case(s, (fi == 10) ? 99 : fi, l, 1'b0);

        // R11: start pulses mid-run do not disturb the poll.
        run_case(6, 99, 1, 1'b1);
        run_case(3, 2, 0, 1'b1);

        // R10: abort during the second read of a pair, then resume.
        s_stop = 1000; f_rise = 99; lat = 3; const_mode = 0;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
        exp_addr = 17'h0ABCD;
        pulse_start(exp_addr);
        while (!(rd_cnt == 1 && bus_rd && !bus_ready)) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        repeat (20) @(negedge clk);
        check(!busy, "R10 idle after abort", busy, 0);
        check(done_cnt == 0, "R10 no done after abort", done_cnt, 0);
        check(rd_cnt == 2, "R10 in-flight read finished", rd_cnt, 2);
        check(wr_cnt == 0, "R10 no write after abort", wr_cnt, 0);
        const_mode = 1; rd_cnt = 0;
        pulse_start(exp_addr);
        while (!done && cycles < 180000) @(negedge clk);
        check(pass && !fail, "R10 resume result", pass, 1);
        check(rd_cnt == 2, "R10 resume fresh pair", rd_cnt, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule